// File: doc/BRIEF.md
# Banked Shared-Cache Capacity Allocator

At each epoch boundary this block decides how a banked shared last-level cache is divided among the cores that use it. It reads one cumulative hit curve per core from the profilers. Entry `w` of a curve is the number of hits that core would have seen with `w` ways. The allocator then hands out capacity greedily. Each grant goes to the core that gains the most hits for each way added.

The cache has eight local banks, where bank `b` sits next to core `b`, and eight central banks. Every bank has eight ways. A run starts by giving each core one way of its own local bank. It then gives away all central banks as whole units. A core that wins its first central bank also takes the rest of its local bank, so it holds the full local bank and that central bank. Such a core is done and takes no part in the way-level phase. That phase hands out the remaining local ways one at a time. A local bank may be shared only inside a neighbour pair (cores `2i` and `2i+1`). Hits per way are compared by cross-multiplication, so no divider is needed. Ties go to the lowest core index.

The result is given per bank. For each central bank the output is its owner core. For each local bank `b` the output is the number of its ways kept by core `b`. The remaining ways of that bank belong to the neighbour core `b^1`.

Top module: `bank_mu_alloc`

## Requirements
- R1: After reset every local-bank keep count is 8, every central-bank owner is core 0 and `done_o` is low.
- R2: Hit curve point `w` (0 to 72) of core `c` is read from `hits_i[(c*73+w)*16 +: 16]`. Curves are assumed to be nondecreasing.
- R3: A run first reserves one local way per core, so that at completion every keep count is at least 1.
- R4: All 8 central banks are granted before any way-level grant. They are granted in bank order: central index 0 first, and owner `j` sits at `owner_o[3j +: 3]`. Each grant goes to the core with the largest `(H[a+n]-H[a])/n`, where `a` is the core's current way count. `n` is `16-a` for a core that holds no central bank yet and 8 for a core that already holds one.
- R5: A core that owns any central bank keeps all 8 ways of its local bank.
- R6: After the central phase, the remaining local ways are granted one at a time to the core with the largest `H[a+1]-H[a]`. A core is eligible only if it owns no central bank and free ways remain in its own bank or, when the neighbour owns no central bank, in the pair's two banks.
- R7: On equal hits per way, the lower core index wins.
- R8: Keep count `b` (at `keep_o[4b +: 4]`) is `min(ways of core b, 8)`. The other `8-keep` ways of local bank `b` belong to core `b^1`.
- R9: `done_o` pulses high for exactly one cycle once all 128 ways are assigned. The outputs then hold, whatever `hits_i` does, until the next start.
- R10: A `start_i` pulse during a run abandons that run and restarts with the curves present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins an allocation run |
| hits_i | input | NCORE*(WAYS*(NCEN+1)+1)*HW (9344) | Cumulative hit curves, one point per way count per core |
| done_o | output | 1 | One-cycle pulse when the allocation is complete |
| keep_o | output | NCORE*$clog2(WAYS+1) (32) | Ways of each local bank kept by its home core |
| owner_o | output | NCEN*$clog2(NCORE) (24) | Owning core of each central bank |

## Verification
The assertions check on every cycle that `done_o` is a single-cycle pulse and that a start clears it. They also check that the outputs cannot move while the allocator is idle. At each completion they check that every core holds at least one local way and that every central-bank owner keeps its full local bank. Only the bench scenarios can show that the greedy order, the cross-multiplied comparison, the pair limits and the lowest-index tie rule give the right split. The bench compares every bank against a model computed from the requirements, for flat, linear, saturating, cliff-shaped and irregular curves, and also for a restart in the middle of a run.

// File: rtl/bank_mu_alloc.sv
module bank_mu_alloc #(
  parameter int NCORE = 8,
  parameter int WAYS  = 8,
  parameter int NCEN  = 8,
  parameter int HW    = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start_i,
  input  logic [NCORE*(WAYS*(NCEN+1)+1)*HW-1:0]        hits_i,
  output logic                                         done_o,
  output logic [NCORE*$clog2(WAYS+1)-1:0]              keep_o,
  output logic [NCEN*$clog2(NCORE)-1:0]                owner_o
);
  localparam int MAXW = WAYS * (NCEN + 1);
  localparam int NPT  = MAXW + 1;
  localparam int CW   = $clog2(NCORE);
  localparam int KW   = $clog2(WAYS + 1);
  localparam int AW   = $clog2(MAXW + 1);
  localparam int NW   = $clog2(2 * WAYS + 1);
  localparam int GW   = $clog2(NCEN);
  localparam int TOT  = WAYS * (NCORE + NCEN);
  localparam int RW   = $clog2(TOT + 1);
  localparam int PW   = HW + NW;

  logic [AW-1:0] a [NCORE];
  logic [NCORE-1:0] fin;
  logic [CW-1:0] own [NCEN];
  logic [GW-1:0] cgiv;
  logic [RW-1:0] rem;
  logic ph, busy, gnt, bv;
  logic [CW-1:0] idx, bc, p;
  logic [HW-1:0] bg, hlo, hhi, gain;
  logic [NW-1:0] bn, n;
  logic [AW:0] free, hiw;
  logic elig, better;

  assign p = idx ^ CW'(1);

  always_comb begin
    if (!ph) begin
      elig = 1'b1;
      n    = fin[idx] ? NW'(WAYS) : NW'(2 * WAYS) - NW'(a[idx]);
      free = '0;
    end else begin
      free = fin[p] ? (AW+1)'(WAYS) - {1'b0, a[idx]}
                    : (AW+1)'(2 * WAYS) - {1'b0, a[idx]} - {1'b0, a[p]};
      elig = !fin[idx] && (free != '0);
      n    = NW'(1);
    end
    hiw = {1'b0, a[idx]} + (AW+1)'(n);
    if (hiw > (AW+1)'(MAXW)) hiw = (AW+1)'(MAXW);
    hlo  = hits_i[(int'(idx) * NPT + int'(a[idx])) * HW +: HW];
    hhi  = hits_i[(int'(idx) * NPT + int'(hiw)) * HW +: HW];
    gain = hhi - hlo;
    better = !bv || ((PW'(gain) * PW'(bn)) > (PW'(bg) * PW'(n)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCORE; c++) a[c] <= AW'(WAYS);
      for (int j = 0; j < NCEN; j++) own[j] <= '0;
      fin <= '0; cgiv <= '0; rem <= '0; ph <= 1'b0;
      busy <= 1'b0; gnt <= 1'b0; bv <= 1'b0; idx <= '0;
      bc <= '0; bg <= '0; bn <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        for (int c = 0; c < NCORE; c++) a[c] <= AW'(1);
        for (int j = 0; j < NCEN; j++) own[j] <= '0;
        fin <= '0; cgiv <= '0; rem <= RW'(TOT - NCORE); ph <= 1'b0;
        busy <= 1'b1; gnt <= 1'b0; bv <= 1'b0; idx <= '0;
      end else if (busy && gnt) begin
        a[bc] <= a[bc] + AW'(bn);
        rem   <= rem - RW'(bn);
        bv    <= 1'b0;
        gnt   <= 1'b0;
        idx   <= '0;
        if (!ph) begin
          fin[bc]   <= 1'b1;
          own[cgiv] <= bc;
          cgiv      <= cgiv + GW'(1);
          if (cgiv == GW'(NCEN - 1)) ph <= 1'b1;
        end
        if (rem == RW'(bn)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (busy) begin
        if (elig && better) begin
          bv <= 1'b1; bc <= idx; bg <= gain; bn <= n;
        end
        if (idx == CW'(NCORE - 1)) gnt <= 1'b1;
        else idx <= idx + CW'(1);
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_keep
    assign keep_o[c*KW +: KW] = (a[c] > AW'(WAYS)) ? KW'(WAYS) : KW'(a[c]);
  end
  for (genvar j = 0; j < NCEN; j++) begin : g_own
    assign owner_o[j*CW +: CW] = own[j];
  end
endmodule

// File: rtl/bank_mu_alloc_chk.sv
module bank_mu_alloc_chk #(
  parameter int NCORE = 8,
  parameter int WAYS  = 8,
  parameter int NCEN  = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start_i,
  input logic                          busy,
  input logic                          done_o,
  input logic [NCORE*$clog2(WAYS+1)-1:0] keep_o,
  input logic [NCEN*$clog2(NCORE)-1:0]   owner_o
);
  localparam int KW = $clog2(WAYS + 1);
  localparam int CW = $clog2(NCORE);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> ($stable(keep_o) && $stable(owner_o)));

  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);

  for (genvar c = 0; c < NCORE; c++) begin : g_res
    a_r3_min_way: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (keep_o[c*KW +: KW] != '0));
  end

  for (genvar j = 0; j < NCEN; j++) begin : g_cen
    logic [CW-1:0] ow;
    assign ow = owner_o[j*CW +: CW];
    a_r5_central_full: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (keep_o[int'(ow)*KW +: KW] == KW'(WAYS)));
  end
endmodule

bind bank_mu_alloc bank_mu_alloc_chk #(.NCORE(NCORE), .WAYS(WAYS), .NCEN(NCEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy),
  .done_o(done_o), .keep_o(keep_o), .owner_o(owner_o));

// File: tb/bank_mu_alloc_tb_top.sv
`timescale 1ns/1ps
module bank_mu_alloc_tb_top;
  localparam int NC = 8, W = 8, NCEN = 8, HW = 16, NPT = 73, KW = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NC*NPT*HW-1:0] hits = '0;
  logic done;
  logic [NC*KW-1:0] keep;
  logic [NCEN*CW-1:0] owner;
  int tests = 0, fails = 0;
  int exp_keep [NC];
  int exp_own [NCEN];

  always #2.5 clk = ~clk;

  bank_mu_alloc dut_i (.clk(clk), .rst_n(rst_n), .start_i(start), .hits_i(hits),
                       .done_o(done), .keep_o(keep), .owner_o(owner));

  function automatic int hv(int pat, int c, int w);
    int s = 0;
    case (pat)
      0: return 0;
      1: return w * (c + 1);
      2: return ((w < 2 + c * 5) ? w : 2 + c * 5) * (9 - c);
      3: if (c == 5) return (w < 16) ? w : 2000 + w;
         else return w * 3;
      default: begin
        for (int i = 0; i < w; i++) s += (c * 37 + i * 11 + pat * 5) % 13;
        return s;
      end
    endcase
  endfunction

  task automatic load(int pat);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NPT; w++)
        hits[(c*NPT+w)*HW +: HW] = HW'(hv(pat, c, w));
  endtask

  task automatic model(int pat);
    int a [NC];
    bit fin [NC];
    int cg, rem, bc, bg, bn, n, f, g;
    bit ph, el;
    cg = 0; rem = 120; ph = 0;
    for (int c = 0; c < NC; c++) begin a[c] = 1; fin[c] = 0; end
    while (rem > 0) begin
      bc = -1; bg = 0; bn = 1;
      for (int c = 0; c < NC; c++) begin
        if (!ph) begin el = 1; n = fin[c] ? 8 : 16 - a[c]; end
        else begin
          f = fin[c^1] ? 8 - a[c] : 16 - a[c] - a[c^1];
          el = !fin[c] && f > 0; n = 1;
        end
        if (el) begin
          g = hv(pat, c, a[c] + n) - hv(pat, c, a[c]);
          if (bc < 0 || g * bn > bg * n) begin bc = c; bg = g; bn = n; end
        end
      end
      a[bc] += bn; rem -= bn;
      if (!ph) begin
        fin[bc] = 1; exp_own[cg] = bc; cg++;
        if (cg == NCEN) ph = 1;
      end
    end
    for (int c = 0; c < NC; c++) exp_keep[c] = (a[c] > 8) ? 8 : a[c];
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    chk(done === 1'b1, "R9 done seen", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic compare(string tag);
    for (int b = 0; b < NC; b++) begin
      chk(int'(keep[b*KW +: KW]) == exp_keep[b], {tag, " R8 keep"},
          int'(keep[b*KW +: KW]), exp_keep[b]);
      chk(keep[b*KW +: KW] >= 1, "R3 reserved way", int'(keep[b*KW +: KW]), 1);
    end
    for (int j = 0; j < NCEN; j++) begin
      chk(int'(owner[j*CW +: CW]) == exp_own[j], {tag, " R4 owner"},
          int'(owner[j*CW +: CW]), exp_own[j]);
      chk(int'(keep[int'(owner[j*CW +: CW])*KW +: KW]) == 8, "R5 owner full local",
          int'(keep[int'(owner[j*CW +: CW])*KW +: KW]), 8);
    end
  endtask

  task automatic run(int pat, string tag);
    load(pat); model(pat);
    pulse_start();
    wait_done();
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R1 done low", int'(done), 0);
    for (int b = 0; b < NC; b++)
      chk(int'(keep[b*KW +: KW]) == 8, "R1 keep reset", int'(keep[b*KW +: KW]), 8);
    for (int j = 0; j < NCEN; j++)
      chk(int'(owner[j*CW +: CW]) == 0, "R1 owner reset", int'(owner[j*CW +: CW]), 0);

    run(0, "R2 R7 flat");
    chk(int'(keep[3*KW +: KW]) == 1, "R7 tie lowest index", int'(keep[3*KW +: KW]), 1);
    chk(int'(keep[2*KW +: KW]) == 8, "R6 pair overflow", int'(keep[2*KW +: KW]), 8);
    chk(int'(owner[7*CW +: CW]) == 0, "R7 tie central", int'(owner[7*CW +: CW]), 0);
    run(1, "R4 linear");
    run(2, "R6 saturating");
    run(3, "R4 cliff");
    run(4, "R6 irregular a");
    run(5, "R6 irregular b");

    load(1);
    repeat (30) @(negedge clk);
    for (int b = 0; b < NC; b++)
      chk(int'(keep[b*KW +: KW]) == exp_keep[b], "R9 hold keep", int'(keep[b*KW +: KW]), exp_keep[b]);
    for (int j = 0; j < NCEN; j++)
      chk(int'(owner[j*CW +: CW]) == exp_own[j], "R9 hold owner", int'(owner[j*CW +: CW]), exp_own[j]);

    load(1);
    pulse_start();
    repeat (40) begin
      @(negedge clk);
      chk(done === 1'b0, "R10 no early done", int'(done), 0);
    end
    load(6); model(6);
    pulse_start();
    wait_done();
    compare("R10 restart");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule